// File: doc/BRIEF.md
# Processor Reset and Interrupt Poll Controller

This block sits beside the sequencer of an 8-bit processor. It decides what the architectural registers hold after a power-on or soft reset, and it decides whether an interrupt is taken when an instruction finishes. On any reset it publishes new accumulator, index, stack pointer and status values. It then reads the two-byte start address from a fixed vector location over a valid/ready request channel. While that read is in progress it holds the peripheral clock enable low, so peripherals do not advance during the vector reads.

The interrupt decision is pipelined on purpose. The request condition is either a pending non-maskable event, or at least one active maskable source while the interrupt-disable flag is clear. This condition is captured once per processor cycle, then delayed by one more cycle. The value used at an instruction boundary is therefore the one seen on the second-to-last cycle of that instruction. Both capture registers freeze while a sprite copy or a sample fetch DMA stalls the processor.

Maskable sources are counted by a small saturating counter with one increment and one decrement input per source.

The vector request channel follows these back-pressure rules:
- `vec_req_valid` stays high, with `vec_addr` stable, until a cycle with `vec_req_ready` high.
- `vec_rsp_valid` is accepted in any later cycle, and the controller waits for it.

Top module: `rstirq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the cycle after a `hard_rst` pulse, the outputs are A=X=Y=0x00, SP=0xFD and P=0x24. P=0x24 means status bit 5 (reserved) and bit 2 (interrupt-disable) are set.
- R2: On the cycle after a `soft_rst` pulse, A, X and Y equal the `cur_a`, `cur_x` and `cur_y` inputs. SP equals `cur_sp` minus 3, modulo 256. P equals `cur_p` with bit 2 set. `hard_rst` wins if both resets pulse together.
- R3: After any reset, the controller issues two vector requests: first address 0xFFFC (low byte), then 0xFFFD (high byte). Each request is held until accepted. PC becomes {high,low}, and `init_done` pulses for one cycle when the high byte has been captured.
- R4: `periph_tick` equals `cyc_en` while no vector fetch is in progress, and is 0 while `busy` is high.
- R5: The request condition is true when the non-maskable flag is set, or when the source count is nonzero and `i_flag` is 0. `nmi_set` sets the flag; `nmi_clr` clears it, with set winning if both arrive together.
- R6: The condition is registered on each enabled cycle, and that value is registered again on the next. A condition that becomes true at a clock edge reaches `take_irq` after two further enabled edges.
- R7: `take_irq` is high only in a cycle where `instr_end` and `cyc_en` are high and the delayed sample is true.
- R8: A `spr_dma_go` or `dmc_dma_go` pulse raises `dma_stall` from the next cycle until the matching end pulse. While `dma_stall` is high, both sample registers hold their values.
- R9: The source count moves by the number of increments minus the number of decrements each cycle. It stays at its ceiling of 2^CNT_W-1 and its floor of 0.
- R10: Any reset clears the non-maskable flag, the source count and both DMA-active states.
- R11: While `cyc_en` is low, both sample registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hard_rst | input | 1 | Synchronous cold reset pulse |
| soft_rst | input | 1 | Synchronous warm reset pulse |
| cur_a | input | DATA_W | Present accumulator, kept on soft reset |
| cur_x | input | DATA_W | Present X index |
| cur_y | input | DATA_W | Present Y index |
| cur_sp | input | DATA_W | Present stack pointer |
| cur_p | input | DATA_W | Present status register |
| i_flag | input | 1 | Interrupt-disable flag |
| cyc_en | input | 1 | Processor cycle strobe |
| instr_end | input | 1 | Last cycle of the current instruction |
| nmi_set | input | 1 | Non-maskable event seen |
| nmi_clr | input | 1 | Non-maskable event serviced |
| src_inc | input | NSRC | Per-source assert of a maskable request |
| src_dec | input | NSRC | Per-source release of a maskable request |
| spr_dma_go | input | 1 | Sprite copy DMA begins |
| spr_dma_end | input | 1 | Sprite copy DMA ends |
| dmc_dma_go | input | 1 | Sample fetch DMA begins |
| dmc_dma_end | input | 1 | Sample fetch DMA ends |
| vec_req_valid | output | 1 | Vector byte read request |
| vec_req_ready | input | 1 | Memory accepts the request |
| vec_addr | output | ADDR_W | Vector byte address |
| vec_rsp_valid | input | 1 | Read data is present |
| vec_rsp_data | input | DATA_W | Read data |
| reg_a | output | DATA_W | Accumulator value to load |
| reg_x | output | DATA_W | X value to load |
| reg_y | output | DATA_W | Y value to load |
| reg_sp | output | DATA_W | Stack pointer value to load |
| reg_p | output | DATA_W | Status value to load |
| reg_pc | output | 2*DATA_W | Program counter from the vector |
| busy | output | 1 | Vector fetch in progress |
| init_done | output | 1 | One-cycle pulse when the PC is complete |
| periph_tick | output | 1 | Peripheral clock enable |
| dma_stall | output | 1 | A DMA is stalling the processor |
| take_irq | output | 1 | Take an interrupt at this instruction boundary |

## Verification
The bench builds the block with NSRC=2 and CNT_W=2. With these values the count ceiling of 3 is reached after three increments, so both saturation edges can be hit in a few cycles. Both sources are driven, so simultaneous increments and decrements can be exercised. The memory model stalls the vector requests with an irregular ready pattern, which exercises the hold rule. Two different vector contents let cold and warm restarts be told apart by their PC.

// File: rtl/rstirq_pkg.sv
package rstirq_pkg;
  typedef enum logic [2:0] {
    VF_IDLE,
    VF_LO_REQ,
    VF_LO_RSP,
    VF_HI_REQ,
    VF_HI_RSP
  } vf_state_t;

  localparam int P_BIT_I   = 2;
  localparam int P_BIT_RSV = 5;
endpackage

// File: rtl/rstirq_regs.sv
module rstirq_regs
  import rstirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC,
  parameter logic [DATA_W-1:0] SP_COLD = 8'hFD,
  parameter int SP_WARM_DEC = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hard_rst,
  input  logic                  soft_rst,
  input  logic [DATA_W-1:0]     cur_a,
  input  logic [DATA_W-1:0]     cur_x,
  input  logic [DATA_W-1:0]     cur_y,
  input  logic [DATA_W-1:0]     cur_sp,
  input  logic [DATA_W-1:0]     cur_p,
  output logic                  vec_req_valid,
  input  logic                  vec_req_ready,
  output logic [ADDR_W-1:0]     vec_addr,
  input  logic                  vec_rsp_valid,
  input  logic [DATA_W-1:0]     vec_rsp_data,
  output logic [DATA_W-1:0]     reg_a,
  output logic [DATA_W-1:0]     reg_x,
  output logic [DATA_W-1:0]     reg_y,
  output logic [DATA_W-1:0]     reg_sp,
  output logic [DATA_W-1:0]     reg_p,
  output logic [2*DATA_W-1:0]   reg_pc,
  output logic                  busy,
  output logic                  init_done
);
  localparam logic [DATA_W-1:0] P_COLD  = DATA_W'((1 << P_BIT_RSV) | (1 << P_BIT_I));
  localparam logic [DATA_W-1:0] P_IMASK = DATA_W'(1 << P_BIT_I);
  localparam logic [DATA_W-1:0] SP_DEC  = DATA_W'(SP_WARM_DEC);

  vf_state_t state;

  assign vec_req_valid = (state == VF_LO_REQ) || (state == VF_HI_REQ);
  assign vec_addr      = (state == VF_HI_REQ) ? VEC_ADDR + ADDR_W'(1) : VEC_ADDR;
  assign busy          = (state != VF_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a     <= '0;
      reg_x     <= '0;
      reg_y     <= '0;
      reg_sp    <= SP_COLD;
      reg_p     <= P_COLD;
      reg_pc    <= '0;
      state     <= VF_LO_REQ;
      init_done <= 1'b0;
    end else if (hard_rst) begin
      reg_a     <= '0;
      reg_x     <= '0;
      reg_y     <= '0;
      reg_sp    <= SP_COLD;
      reg_p     <= P_COLD;
      state     <= VF_LO_REQ;
      init_done <= 1'b0;
    end else if (soft_rst) begin
      reg_a     <= cur_a;
      reg_x     <= cur_x;
      reg_y     <= cur_y;
      reg_sp    <= cur_sp - SP_DEC;
      reg_p     <= cur_p | P_IMASK;
      state     <= VF_LO_REQ;
      init_done <= 1'b0;
    end else begin
      init_done <= 1'b0;
      case (state)
        VF_LO_REQ: if (vec_req_ready) state <= VF_LO_RSP;
        VF_LO_RSP: if (vec_rsp_valid) begin
          reg_pc[DATA_W-1:0] <= vec_rsp_data;
          state <= VF_HI_REQ;
        end
        VF_HI_REQ: if (vec_req_ready) state <= VF_HI_RSP;
        VF_HI_RSP: if (vec_rsp_valid) begin
          reg_pc[2*DATA_W-1:DATA_W] <= vec_rsp_data;
          state     <= VF_IDLE;
          init_done <= 1'b1;
        end
        default: state <= VF_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_valid && !vec_req_ready && !hard_rst && !soft_rst)
      |=> (vec_req_valid && $stable(vec_addr)));

  // R2
  warm_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !hard_rst) |=> (reg_sp == $past(cur_sp) - SP_DEC));

  // R1
  cold_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (reg_p == P_COLD && reg_a == '0 && reg_sp == SP_COLD));
endmodule

// File: rtl/rstirq_srccnt.sv
module rstirq_srccnt #(
  parameter int NSRC  = 4,
  parameter int CNT_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NSRC-1:0] inc,
  input  logic [NSRC-1:0] dec,
  output logic            active
);
  localparam int UPW = $clog2(NSRC + 1);
  localparam int SW  = ((CNT_W > UPW) ? CNT_W : UPW) + 1;
  localparam logic [SW-1:0] CEIL = SW'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt, nxt;
  logic [SW-1:0]    up, dn, sum, diff;

  always_comb begin
    up = '0;
    dn = '0;
    for (int i = 0; i < NSRC; i++) begin
      up = up + SW'(inc[i]);
      dn = dn + SW'(dec[i]);
    end
    sum  = SW'(cnt) + up;
    diff = sum - dn;
    if (sum < dn)        nxt = '0;
    else if (diff > CEIL) nxt = CEIL[CNT_W-1:0];
    else                 nxt = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= nxt;
  end

  assign active = (cnt != '0);

  // R9
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == '0 && inc == '0) |=> (cnt == '0));

  // R9
  ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == CEIL[CNT_W-1:0] && dec == '0) |=> (cnt == CEIL[CNT_W-1:0]));
endmodule

// File: rtl/rstirq_sampler.sv
module rstirq_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cyc_en,
  input  logic nmi_set,
  input  logic nmi_clr,
  input  logic src_active,
  input  logic i_flag,
  input  logic spr_dma_go,
  input  logic spr_dma_end,
  input  logic dmc_dma_go,
  input  logic dmc_dma_end,
  output logic run_prev,
  output logic dma_stall
);
  logic nmi_flag, spr_act, dmc_act, run_now, cond;

  assign cond      = nmi_flag || (src_active && !i_flag);
  assign dma_stall = spr_act || dmc_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_flag <= 1'b0;
      spr_act  <= 1'b0;
      dmc_act  <= 1'b0;
    end else if (clr) begin
      nmi_flag <= 1'b0;
      spr_act  <= 1'b0;
      dmc_act  <= 1'b0;
    end else begin
      if (nmi_set)          nmi_flag <= 1'b1;
      else if (nmi_clr)     nmi_flag <= 1'b0;
      if (spr_dma_go)       spr_act  <= 1'b1;
      else if (spr_dma_end) spr_act  <= 1'b0;
      if (dmc_dma_go)       dmc_act  <= 1'b1;
      else if (dmc_dma_end) dmc_act  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_now  <= 1'b0;
      run_prev <= 1'b0;
    end else if (clr) begin
      run_now  <= 1'b0;
      run_prev <= 1'b0;
    end else if (cyc_en && !dma_stall) begin
      run_now  <= cond;
      run_prev <= run_now;
    end
  end

  // R8
  dma_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_stall && !clr) |=> ($stable(run_now) && $stable(run_prev)));

  // R11
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !clr) |=> ($stable(run_now) && $stable(run_prev)));

  // R6
  delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !dma_stall && !clr) |=> (run_prev == $past(run_now)));
endmodule

// File: rtl/rstirq_ctrl.sv
module rstirq_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int NSRC   = 4,
  parameter int CNT_W  = 3,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC,
  parameter logic [DATA_W-1:0] SP_COLD  = 8'hFD,
  parameter int SP_WARM_DEC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hard_rst,
  input  logic                soft_rst,
  input  logic [DATA_W-1:0]   cur_a,
  input  logic [DATA_W-1:0]   cur_x,
  input  logic [DATA_W-1:0]   cur_y,
  input  logic [DATA_W-1:0]   cur_sp,
  input  logic [DATA_W-1:0]   cur_p,
  input  logic                i_flag,
  input  logic                cyc_en,
  input  logic                instr_end,
  input  logic                nmi_set,
  input  logic                nmi_clr,
  input  logic [NSRC-1:0]     src_inc,
  input  logic [NSRC-1:0]     src_dec,
  input  logic                spr_dma_go,
  input  logic                spr_dma_end,
  input  logic                dmc_dma_go,
  input  logic                dmc_dma_end,
  output logic                vec_req_valid,
  input  logic                vec_req_ready,
  output logic [ADDR_W-1:0]   vec_addr,
  input  logic                vec_rsp_valid,
  input  logic [DATA_W-1:0]   vec_rsp_data,
  output logic [DATA_W-1:0]   reg_a,
  output logic [DATA_W-1:0]   reg_x,
  output logic [DATA_W-1:0]   reg_y,
  output logic [DATA_W-1:0]   reg_sp,
  output logic [DATA_W-1:0]   reg_p,
  output logic [2*DATA_W-1:0] reg_pc,
  output logic                busy,
  output logic                init_done,
  output logic                periph_tick,
  output logic                dma_stall,
  output logic                take_irq
);
  logic any_rst, src_active, run_prev;

  assign any_rst = hard_rst || soft_rst;

  rstirq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR),
    .SP_COLD(SP_COLD), .SP_WARM_DEC(SP_WARM_DEC)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .cur_a(cur_a), .cur_x(cur_x), .cur_y(cur_y), .cur_sp(cur_sp), .cur_p(cur_p),
    .vec_req_valid(vec_req_valid), .vec_req_ready(vec_req_ready),
    .vec_addr(vec_addr), .vec_rsp_valid(vec_rsp_valid), .vec_rsp_data(vec_rsp_data),
    .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_p(reg_p),
    .reg_pc(reg_pc), .busy(busy), .init_done(init_done)
  );

  rstirq_srccnt #(.NSRC(NSRC), .CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(any_rst),
    .inc(src_inc), .dec(src_dec), .active(src_active)
  );

  rstirq_sampler smp_i (
    .clk(clk), .rst_n(rst_n), .clr(any_rst), .cyc_en(cyc_en),
    .nmi_set(nmi_set), .nmi_clr(nmi_clr), .src_active(src_active), .i_flag(i_flag),
    .spr_dma_go(spr_dma_go), .spr_dma_end(spr_dma_end),
    .dmc_dma_go(dmc_dma_go), .dmc_dma_end(dmc_dma_end),
    .run_prev(run_prev), .dma_stall(dma_stall)
  );

  assign periph_tick = cyc_en && !busy;
  assign take_irq    = instr_end && cyc_en && run_prev;

  // R7
  take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (instr_end && cyc_en));

  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |=> !dma_stall);
endmodule

// File: tb/rstirq_ctrl_tb_top.sv
module rstirq_ctrl_tb_top;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int NS = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, hard_rst, soft_rst, i_flag, cyc_en, instr_end, nmi_set, nmi_clr;
  logic [DW-1:0] cur_a, cur_x, cur_y, cur_sp, cur_p;
  logic [NS-1:0] src_inc, src_dec;
  logic spr_dma_go, spr_dma_end, dmc_dma_go, dmc_dma_end;
  logic vec_req_valid, vec_req_ready, vec_rsp_valid;
  logic [AW-1:0] vec_addr;
  logic [DW-1:0] vec_rsp_data;
  logic [DW-1:0] reg_a, reg_x, reg_y, reg_sp, reg_p;
  logic [2*DW-1:0] reg_pc;
  logic busy, init_done, periph_tick, dma_stall, take_irq;

  rstirq_ctrl #(.DATA_W(DW), .ADDR_W(AW), .NSRC(NS), .CNT_W(2)) dut_i (.*);

  int errors = 0;
  int checks = 0;

  typedef struct packed {
    logic [15:0] pc;
    logic [7:0] a, x, y, sp, p;
  } exp_t;
  exp_t sb_q[$];

  logic [7:0] vec_lo = 8'h34, vec_hi = 8'h12;
  bit expect_hi = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic push_exp(logic [15:0] pc, logic [7:0] a, x, y, sp, p);
    exp_t e;
    e.pc = pc; e.a = a; e.x = x; e.y = y; e.sp = sp; e.p = p;
    sb_q.push_back(e);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    check("R3 fetch completes", {31'd0, busy}, 32'd0);
    cyc();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && init_done) begin
      if (sb_q.size() == 0) begin
        check("R3 unexpected init_done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check("R3 pc", {16'd0, reg_pc}, {16'd0, e.pc});
        check("R1/R2 a", {24'd0, reg_a}, {24'd0, e.a});
        check("R1/R2 x", {24'd0, reg_x}, {24'd0, e.x});
        check("R1/R2 y", {24'd0, reg_y}, {24'd0, e.y});
        check("R1/R2 sp", {24'd0, reg_sp}, {24'd0, e.sp});
        check("R1/R2 p", {24'd0, reg_p}, {24'd0, e.p});
      end
    end
  end

  // vector memory responder with back-pressure
  initial begin
    logic [7:0] rdy_pat;
    bit hs, pend;
    logic [AW-1:0] a;
    logic [7:0] pd;
    rdy_pat = 8'b1011_0010;
    pend = 1'b0;
    pd = '0;
    vec_req_ready = 1'b0;
    vec_rsp_valid = 1'b0;
    vec_rsp_data = '0;
    forever begin
      @(negedge clk);
      hs = rst_n && vec_req_valid && vec_req_ready;
      a = vec_addr;
      if (hs) begin
        // R3: low byte address first, then high byte
        check("R3 vector address order", {16'd0, a},
              {16'd0, expect_hi ? 16'hFFFD : 16'hFFFC});
        expect_hi = !expect_hi;
      end
      @(posedge clk);
      #1;
      vec_rsp_valid = 1'b0;
      if (pend) begin
        vec_rsp_valid = 1'b1;
        vec_rsp_data = pd;
        pend = 1'b0;
      end
      if (hs) begin
        pend = 1'b1;
        pd = (a == 16'hFFFD) ? vec_hi : vec_lo;
      end
      vec_req_ready = rdy_pat[0];
      rdy_pat = {rdy_pat[0], rdy_pat[7:1]};
    end
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hard_rst = 0; soft_rst = 0; i_flag = 1; cyc_en = 1; instr_end = 1;
    nmi_set = 0; nmi_clr = 0; src_inc = '0; src_dec = '0;
    spr_dma_go = 0; spr_dma_end = 0; dmc_dma_go = 0; dmc_dma_end = 0;
    cur_a = 8'h11; cur_x = 8'h22; cur_y = 8'h33; cur_sp = 8'h80; cur_p = 8'h01;
    push_exp(16'h1234, 8'h00, 8'h00, 8'h00, 8'hFD, 8'h24);
    cyc(3);
    @(negedge clk);
    // R1 values held during reset
    check("R1 sp in reset", {24'd0, reg_sp}, 32'hFD);
    check("R1 p in reset", {24'd0, reg_p}, 32'h24);
    cyc();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 a after release", {24'd0, reg_a}, 32'h0);
    check("R3 busy after release", {31'd0, busy}, 32'd1);
    // R4 no peripheral tick during fetch
    check("R4 tick during fetch", {31'd0, periph_tick}, 32'd0);
    wait_idle();
    @(negedge clk);
    check("R4 tick when idle", {31'd0, periph_tick}, 32'd1);
    check("R7 no take at rest", {31'd0, take_irq}, 32'd0);

    // R6 two-stage delay of non-maskable event
    cyc();
    nmi_set = 1; cyc(); nmi_set = 0;
    @(negedge clk); check("R6 delay stage 0", {31'd0, take_irq}, 32'd0);
    cyc();
    @(negedge clk); check("R6 delay stage 1", {31'd0, take_irq}, 32'd0);
    cyc();
    @(negedge clk); check("R6 take after two stages", {31'd0, take_irq}, 32'd1);
    cyc();
    instr_end = 0;
    @(negedge clk); check("R7 no take mid instruction", {31'd0, take_irq}, 32'd0);
    cyc(); instr_end = 1;
    nmi_clr = 1; cyc(); nmi_clr = 0;
    cyc(2);
    @(negedge clk); check("R5 nmi cleared", {31'd0, take_irq}, 32'd0);

    // R5 / R9 maskable sources
    cyc();
    i_flag = 1;
    src_inc = 2'b01; cyc(4); src_inc = '0;
    cyc(3);
    @(negedge clk); check("R5 masked by i_flag", {31'd0, take_irq}, 32'd0);
    cyc(); i_flag = 0; cyc(3);
    @(negedge clk); check("R5 unmasked source", {31'd0, take_irq}, 32'd1);
    cyc();
    src_dec = 2'b01; cyc(2); src_dec = '0; cyc(3);
    @(negedge clk); check("R9 ceiling held, count 1 left", {31'd0, take_irq}, 32'd1);
    cyc();
    src_dec = 2'b01; cyc(); src_dec = '0; cyc(3);
    @(negedge clk); check("R9 count back to zero", {31'd0, take_irq}, 32'd0);
    cyc();
    src_dec = 2'b11; cyc(); src_dec = '0;
    src_inc = 2'b01; cyc(); src_inc = '0; cyc(3);
    @(negedge clk); check("R9 floor held", {31'd0, take_irq}, 32'd1);
    cyc();
    src_inc = 2'b01; src_dec = 2'b10; cyc(); src_inc = '0; src_dec = '0; cyc(3);
    @(negedge clk); check("R9 net zero", {31'd0, take_irq}, 32'd1);
    cyc();
    src_dec = 2'b01; cyc(); src_dec = '0; cyc(3);

    // R8 DMA freeze
    spr_dma_go = 1; cyc(); spr_dma_go = 0;
    @(negedge clk); check("R8 stall raised", {31'd0, dma_stall}, 32'd1);
    cyc();
    nmi_set = 1; cyc(); nmi_set = 0; cyc(4);
    @(negedge clk); check("R8 frozen low", {31'd0, take_irq}, 32'd0);
    cyc();
    spr_dma_end = 1; cyc(); spr_dma_end = 0;
    @(negedge clk); check("R8 stall dropped", {31'd0, dma_stall}, 32'd0);
    cyc(2);
    @(negedge clk); check("R8 resumes after dma", {31'd0, take_irq}, 32'd1);
    cyc();
    dmc_dma_go = 1; cyc(); dmc_dma_go = 0;
    nmi_clr = 1; cyc(); nmi_clr = 0; cyc(4);
    @(negedge clk); check("R8 frozen high", {31'd0, take_irq}, 32'd1);
    cyc();
    dmc_dma_end = 1; cyc(); dmc_dma_end = 0; cyc(3);
    @(negedge clk); check("R8 drops after dma", {31'd0, take_irq}, 32'd0);

    // R11 strobe low holds sampling
    cyc();
    cyc_en = 0;
    nmi_set = 1; cyc(); nmi_set = 0; cyc(4);
    @(negedge clk); check("R4 tick gated by strobe", {31'd0, periph_tick}, 32'd0);
    cyc();
    cyc_en = 1;
    @(negedge clk); check("R11 held while strobe low", {31'd0, take_irq}, 32'd0);
    cyc(2);
    @(negedge clk); check("R11 advances with strobe", {31'd0, take_irq}, 32'd1);

    // R10 cold reset clears pending state
    cyc();
    src_inc = 2'b11; cyc(); src_inc = '0;
    spr_dma_go = 1; cyc(); spr_dma_go = 0;
    push_exp(16'h1234, 8'h00, 8'h00, 8'h00, 8'hFD, 8'h24);
    hard_rst = 1; cyc(); hard_rst = 0;
    @(negedge clk);
    check("R10 dma cleared", {31'd0, dma_stall}, 32'd0);
    check("R1 sp after hard reset", {24'd0, reg_sp}, 32'hFD);
    check("R1 p after hard reset", {24'd0, reg_p}, 32'h24);
    wait_idle();
    cyc(3);
    @(negedge clk); check("R10 nmi and count cleared", {31'd0, take_irq}, 32'd0);

    // R2 warm reset
    cyc();
    vec_lo = 8'h78; vec_hi = 8'h56;
    push_exp(16'h5678, 8'h11, 8'h22, 8'h33, 8'h7D, 8'h05);
    soft_rst = 1; cyc(); soft_rst = 0;
    @(negedge clk);
    check("R2 a kept", {24'd0, reg_a}, 32'h11);
    check("R2 sp minus 3", {24'd0, reg_sp}, 32'h7D);
    check("R2 p with I", {24'd0, reg_p}, 32'h05);
    wait_idle();
    cur_sp = 8'h01; cur_p = 8'h24;
    push_exp(16'h5678, 8'h11, 8'h22, 8'h33, 8'hFE, 8'h24);
    soft_rst = 1; cyc(); soft_rst = 0;
    @(negedge clk); check("R2 sp wraps", {24'd0, reg_sp}, 32'hFE);
    wait_idle();
    cur_sp = 8'h40;
    push_exp(16'h5678, 8'h00, 8'h00, 8'h00, 8'hFD, 8'h24);
    soft_rst = 1; hard_rst = 1; cyc(); soft_rst = 0; hard_rst = 0;
    @(negedge clk); check("R2 hard wins", {24'd0, reg_sp}, 32'hFD);
    wait_idle();
    cyc(2);
    check("R3 scoreboard drained", sb_q.size(), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule